// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one down-counting timer channel with a 16-bit reload value, a gate input, a wave output and a live count. A control write selects one of six counting modes and then waits for a count. Each later count write starts the selected behaviour: terminal-count signalling, a gate-triggered one-shot, a rate generator, a square-wave generator, or a single strobe. Counting advances only on clock cycles where the counting-clock enable `tick_en` is high. This lets the channel run from a slow time base while staying synchronous to the block clock.

The control flow is a five-state machine. `ST_NOMODE` is the state after reset. `ST_WAITCNT` is entered after a control write. `ST_ARMED` holds a loaded count while the channel waits for a gate trigger. `ST_COUNT` is the first pass towards the terminal count. `ST_EXPIRED` applies to the one-shot style modes after their terminal count.

The transitions are:
- A control write moves the machine from any state to `ST_WAITCNT`.
- A count write moves it from `ST_WAITCNT`, `ST_ARMED`, `ST_COUNT` or `ST_EXPIRED` to `ST_ARMED` in modes 1 and 5, and to `ST_COUNT` in the other modes.
- A gate rising edge moves it from `ST_ARMED`, `ST_COUNT` or `ST_EXPIRED` to `ST_COUNT` in modes 1, 2, 3 and 5.
- A counted tick that reaches the terminal count moves it from `ST_COUNT` to `ST_EXPIRED` in modes 0, 1, 4 and 5.

A one-cycle `tc_irq` pulse marks each terminal event and can serve as an interrupt request source. A BCD selection bit is stored and reflected, but counting is always binary.

Top module: `pit_channel`

## Requirements
- R1: After reset `wave_out`=0, `count`=0 and `tc_irq`=0. Count writes and gate edges have no effect on any output until a control write has been made.
- R2: A count write of 0 loads a reload value of 65536. `count` then reads 0, and the next counted tick shows 0xFFFF.
- R3: In mode 0 (`cfg_mode`=0), the output is low from the count write onward. Counting begins with the first counted tick after the write. The output rises when the number of elapsed ticks equals the reload value and then stays high. While `gate_in` is low, ticks are not counted.
- R4: In modes 0, 1, 4 and 5, `count` equals the reload value minus the elapsed ticks, modulo 2^16, and it keeps counting past the terminal count. In modes 0 and 4 a gate rising edge does not restart counting.
- R5: In mode 1, a count write arms the channel and leaves `count` at the reload value with the output low. Each gate rising edge restarts the count from the reload value with the output low. The output goes high once the elapsed ticks reach the reload value.
- R6: In mode 2, `count` runs reload−(elapsed mod reload). The output is high only in tick periods where elapsed is a nonzero multiple of the reload value. A gate rising edge restarts the count. Gate level does not pause counting.
- R7: In mode 3, `count` runs reload−((2·elapsed) mod reload). The output is high while (elapsed mod reload) < ceil(reload/2), so the output is high right after a load or restart.
- R8: In modes 4 and 5, the output is high only during the single tick period in which elapsed equals the reload value. Mode 4 starts counting on the count write and pauses while the gate is low. Mode 5 waits for, and restarts on, a gate rising edge.
- R9: `cfg_mode` values 6 and 7 select modes 2 and 3. A control write drives the output low, freezes `count`, and stops counting until the next count write.
- R10: When several inputs act in the same cycle, the priority is control write, then count write, then gate rising edge, then counting tick. A tick in the cycle of a count write or restart is not counted.
- R11: `tc_irq` is high for the one clock cycle after a counted tick that makes elapsed equal the reload value (modes 0, 1, 4, 5, first time only), or a nonzero multiple of it (modes 2 and 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_mode | input | 3 | Counting mode for the control write |
| cfg_bcd | input | 1 | BCD selection stored with the control write |
| load_we | input | 1 | Count write strobe |
| load_val | input | 16 | Reload value (0 means 65536) |
| gate_in | input | 1 | Gate level |
| tick_en | input | 1 | Counting clock enable |
| wave_out | output | 1 | Mode-dependent output waveform |
| tc_irq | output | 1 | One-cycle terminal-count pulse |
| count | output | 16 | Live count value |
| bcd_flag | output | 1 | Stored BCD selection |

## Verification
Every result is registered, so `wave_out`, `count` and `tc_irq` all show the effect of inputs sampled at one rising edge from that edge until the next one. The bench sets each input set at a falling edge. It advances its elapsed-tick model once for the coming rising edge, and compares all three outputs at the following falling edge, exactly one cycle after the stimulus. Gate edges are judged against the gate level of the previous cycle, so a rising edge costs no extra cycle.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

    typedef enum logic [2:0] {
        ST_NOMODE,
        ST_WAITCNT,
        ST_ARMED,
        ST_COUNT,
        ST_EXPIRED
    } pit_state_e;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_CFG,
        CMD_LOAD,
        CMD_ARM,
        CMD_RESTART,
        CMD_STEP
    } pit_cmd_e;

    // Codes 6 and 7 alias the rate and square-wave modes.
    function automatic logic [2:0] canon_mode(input logic [2:0] m);
        return (m > 3'd5) ? (m - 3'd4) : m;
    endfunction

    function automatic logic gate_retriggers(input logic [2:0] m);
        return (m == 3'd1) || (m == 3'd2) || (m == 3'd3) || (m == 3'd5);
    endfunction

    function automatic logic gate_pauses(input logic [2:0] m);
        return (m == 3'd0) || (m == 3'd4);
    endfunction

    function automatic logic waits_for_gate(input logic [2:0] m);
        return (m == 3'd1) || (m == 3'd5);
    endfunction

    function automatic logic single_pass(input logic [2:0] m);
        return (m != 3'd2) && (m != 3'd3);
    endfunction

endpackage

// File: rtl/pit_gate_edge.sv
`timescale 1ns/1ps
module pit_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    output logic rise_o
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_i;
    end

    assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/pit_fsm.sv
`timescale 1ns/1ps
module pit_fsm
    import pit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [2:0] cfg_mode,
    input  logic       cfg_bcd,
    input  logic       load_we,
    input  logic       gate_i,
    input  logic       gate_rise,
    input  logic       tick,
    input  logic       term,
    output pit_state_e state_o,
    output logic [2:0] mode_o,
    output logic       bcd_o,
    output pit_cmd_e   cmd_o
);
    pit_state_e state_q, state_d;
    logic [2:0] mode_q;
    logic       bcd_q;
    logic       step_ok;
    pit_state_e load_target;
    pit_cmd_e   load_cmd;

    // State register and stored configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NOMODE;
            mode_q  <= 3'd7;
            bcd_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cfg_we) begin
                mode_q <= canon_mode(cfg_mode);
                bcd_q  <= cfg_bcd;
            end
        end
    end

    assign step_ok     = tick && (gate_i || !gate_pauses(mode_q));
    assign load_target = waits_for_gate(mode_q) ? ST_ARMED : ST_COUNT;
    assign load_cmd    = waits_for_gate(mode_q) ? CMD_ARM : CMD_LOAD;

    // Next state and command
    always_comb begin
        state_d = state_q;
        cmd_o   = CMD_IDLE;
        if (cfg_we) begin
            state_d = ST_WAITCNT;
            cmd_o   = CMD_CFG;
        end else begin
            unique case (state_q)
                ST_NOMODE: begin
                end
                ST_WAITCNT: begin
                    if (load_we) begin
                        state_d = load_target;
                        cmd_o   = load_cmd;
                    end
                end
                ST_ARMED: begin
                    if (load_we) begin
                        state_d = load_target;
                        cmd_o   = load_cmd;
                    end else if (gate_rise) begin
                        state_d = ST_COUNT;
                        cmd_o   = CMD_RESTART;
                    end
                end
                ST_COUNT, ST_EXPIRED: begin
                    if (load_we) begin
                        state_d = load_target;
                        cmd_o   = load_cmd;
                    end else if (gate_rise && gate_retriggers(mode_q)) begin
                        state_d = ST_COUNT;
                        cmd_o   = CMD_RESTART;
                    end else if (step_ok) begin
                        cmd_o = CMD_STEP;
                        if (state_q == ST_COUNT && term && single_pass(mode_q))
                            state_d = ST_EXPIRED;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign state_o = state_q;
    assign mode_o  = mode_q;
    assign bcd_o   = bcd_q;
endmodule

// File: rtl/pit_datapath.sv
`timescale 1ns/1ps
module pit_datapath
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pit_cmd_e         cmd,
    input  logic [2:0]       mode,
    input  logic             first_pass,
    input  logic [CNT_W-1:0] load_val,
    output logic             out_o,
    output logic             tc_o,
    output logic [CNT_W-1:0] count_o,
    output logic             term_o
);
    localparam int RLD_W = CNT_W + 1;
    localparam logic [RLD_W-1:0] FULL = RLD_W'(1) << CNT_W;
    localparam logic [RLD_W-1:0] ONE  = RLD_W'(1);
    localparam logic [RLD_W-1:0] TWO  = RLD_W'(2);

    logic [RLD_W-1:0] rld_q, cnt_q, load_n, sq_next;
    logic [RLD_W:0]   sq_sum;
    logic             out_q, tc_q;

    assign load_n  = (load_val == '0) ? FULL : {1'b0, load_val};
    assign term_o  = (cnt_q == ONE);
    // Square-wave fold: step by two and add one period when crossing zero.
    assign sq_sum  = {1'b0, cnt_q} + {1'b0, rld_q} - {1'b0, TWO};
    assign sq_next = (sq_sum == '0) ? rld_q : sq_sum[RLD_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= FULL;
            cnt_q <= '0;
            out_q <= 1'b0;
            tc_q  <= 1'b0;
        end else begin
            tc_q <= 1'b0;
            unique case (cmd)
                CMD_IDLE: begin
                end
                CMD_CFG: out_q <= 1'b0;
                CMD_LOAD: begin
                    rld_q <= load_n;
                    cnt_q <= load_n;
                    out_q <= (mode == 3'd3);
                end
                CMD_ARM: begin
                    rld_q <= load_n;
                    cnt_q <= load_n;
                    out_q <= 1'b0;
                end
                CMD_RESTART: begin
                    cnt_q <= rld_q;
                    out_q <= (mode == 3'd3);
                end
                CMD_STEP: begin
                    if (mode == 3'd2) begin
                        if (term_o) begin
                            cnt_q <= rld_q;
                            out_q <= 1'b1;
                            tc_q  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - ONE;
                            out_q <= 1'b0;
                        end
                    end else if (mode == 3'd3) begin
                        if (cnt_q <= TWO) begin
                            cnt_q <= sq_next;
                            if (rld_q != ONE) out_q <= ~out_q;
                            tc_q <= ~out_q | (rld_q == ONE);
                        end else begin
                            cnt_q <= cnt_q - TWO;
                        end
                    end else begin
                        cnt_q <= cnt_q - ONE;
                        if (first_pass && term_o) begin
                            out_q <= 1'b1;
                            tc_q  <= 1'b1;
                        end else if (!first_pass && (mode == 3'd4 || mode == 3'd5)) begin
                            out_q <= 1'b0;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign out_o   = out_q;
    assign tc_o    = tc_q;
    assign count_o = cnt_q[CNT_W-1:0];
endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_bcd,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic             gate_in,
    input  logic             tick_en,
    output logic             wave_out,
    output logic             tc_irq,
    output logic [CNT_W-1:0] count,
    output logic             bcd_flag
);
    pit_state_e fsm_state;
    pit_cmd_e   fsm_cmd;
    logic [2:0] cur_mode;
    logic       gate_rise;
    logic       at_term;

    pit_gate_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_i (gate_in),
        .rise_o (gate_rise)
    );

    pit_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_mode  (cfg_mode),
        .cfg_bcd   (cfg_bcd),
        .load_we   (load_we),
        .gate_i    (gate_in),
        .gate_rise (gate_rise),
        .tick      (tick_en),
        .term      (at_term),
        .state_o   (fsm_state),
        .mode_o    (cur_mode),
        .bcd_o     (bcd_flag),
        .cmd_o     (fsm_cmd)
    );

    pit_datapath #(.CNT_W(CNT_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (fsm_cmd),
        .mode       (cur_mode),
        .first_pass (fsm_state == ST_COUNT),
        .load_val   (load_val),
        .out_o      (wave_out),
        .tc_o       (tc_irq),
        .count_o    (count),
        .term_o     (at_term)
    );
endmodule

// File: rtl/pit_channel_chk.sv
`timescale 1ns/1ps
module pit_channel_chk
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             load_we,
    input logic             gate_in,
    input logic             tick_en,
    input logic             wave_out,
    input logic             tc_irq,
    input logic [CNT_W-1:0] count,
    input pit_state_e       state,
    input logic [2:0]       mode
);
    // R1: no configuration yet means a quiet output and a zero count
    assert_quiet_nomode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NOMODE) |-> (!wave_out && count == '0));

    // R1: nothing but a control write can move the count before configuration
    assert_hold_nomode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NOMODE && !cfg_we) |=> $stable(count));

    // R3: mode 0 output stays high until a new write
    assert_sticky_mode0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && wave_out && !cfg_we && !load_we) |=> wave_out);

    // R4: counted tick in modes 0/4 lowers the count by one
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd0 || mode == 3'd4) && (state == ST_COUNT || state == ST_EXPIRED)
         && tick_en && gate_in && !cfg_we && !load_we)
        |=> (count == $past(count) - 1'b1));

    // R7: a square-wave load starts in the high half
    assert_square_starts_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && state != ST_NOMODE && load_we && !cfg_we) |=> wave_out);

    // R11: a terminal pulse follows a counted tick
    assert_tc_after_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tc_irq |-> $past(tick_en));
endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .load_we  (load_we),
    .gate_in  (gate_in),
    .tick_en  (tick_en),
    .wave_out (wave_out),
    .tc_irq   (tc_irq),
    .count    (count),
    .state    (fsm_state),
    .mode     (cur_mode)
);

// File: tb/pit_channel_tb.sv
`timescale 1ns/1ps
module pit_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic        cfg_bcd = 1'b0;
    logic        load_we = 1'b0;
    logic [15:0] load_val = 16'd0;
    logic        gate_in = 1'b0;
    logic        tick_en = 1'b0;
    logic        wave_out, tc_irq, bcd_flag;
    logic [15:0] count;

    always #2.5 clk = ~clk;

    pit_channel dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_bcd(cfg_bcd), .load_we(load_we), .load_val(load_val),
        .gate_in(gate_in), .tick_en(tick_en), .wave_out(wave_out),
        .tc_irq(tc_irq), .count(count), .bcd_flag(bcd_flag)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    string cur_req  = "R1";
    bit    g_lvl    = 0;

    // Behavioural model: phase 0 none, 1 waiting for count, 2 armed, 3 running
    int m_phase, m_mode, m_n, m_hold, m_d;
    bit m_gp, m_chg;

    function automatic int e_count();
        if (m_phase != 3) return m_hold;
        if (m_mode == 2) return (m_n - (m_d % m_n)) & 16'hffff;
        if (m_mode == 3) return (m_n - ((2 * m_d) % m_n)) & 16'hffff;
        return (m_n - m_d) & 16'hffff;
    endfunction

    function automatic bit e_out();
        if (m_phase != 3) return 0;
        case (m_mode)
            0, 1:    return m_d >= m_n;
            2:       return (m_d % m_n == 0) && (m_d != 0);
            3:       return (m_d % m_n) < ((m_n + 1) / 2);
            default: return m_d == m_n;
        endcase
    endfunction

    function automatic bit e_tc();
        if (m_phase != 3 || !m_chg) return 0;
        if (m_mode == 2 || m_mode == 3) return (m_d % m_n) == 0;
        return m_d == m_n;
    endfunction

    task automatic model_step(bit c, int cm, bit l, int lv, bit g, bit t);
        bit rise;
        rise  = g && !m_gp;
        m_gp  = g;
        m_chg = 0;
        if (c) begin
            m_hold  = e_count();
            m_mode  = (cm > 5) ? cm - 4 : cm;
            m_phase = 1;
        end else if (l && m_phase != 0) begin
            m_n = (lv == 0) ? 65536 : lv;
            if (m_mode == 1 || m_mode == 5) begin
                m_phase = 2;
                m_hold  = m_n & 16'hffff;
            end else begin
                m_phase = 3;
                m_d     = 0;
            end
        end else if (rise && m_phase >= 2 && m_mode != 0 && m_mode != 4) begin
            m_phase = 3;
            m_d     = 0;
        end else if (m_phase == 3 && t && (g || (m_mode != 0 && m_mode != 4))) begin
            m_d   = m_d + 1;
            m_chg = 1;
        end
    endtask

    task automatic compare();
        int eo, et, ec;
        eo = e_out(); et = e_tc(); ec = e_count();
        n_checks++;
        if (wave_out !== eo[0] || tc_irq !== et[0] || count !== ec[15:0]) begin
            n_fail++;
            $display("FAIL %s: out=%0b tc=%0b count=%0h, expected out=%0b tc=%0b count=%0h",
                     cur_req, wave_out, tc_irq, count, eo[0], et[0], ec[15:0]);
        end
    endtask

    task automatic cyc(bit c, int cm, bit l, int lv, bit t);
        cfg_we   = c;
        cfg_mode = cm[2:0];
        load_we  = l;
        load_val = lv[15:0];
        gate_in  = g_lvl;
        tick_en  = t;
        model_step(c, cm, l, lv, g_lvl, t);
        @(negedge clk);
        compare();
    endtask

    task automatic run(int n, int div = 1);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, (i % div) == 0);
    endtask

    task automatic cfg(int m);  cyc(1, m, 0, 0, 1); endtask
    task automatic load(int v); cyc(0, 0, 1, v, 1); endtask

    initial begin
        m_phase = 0; m_mode = 7; m_n = 65536; m_hold = 0; m_d = 0; m_gp = 0; m_chg = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state and ignored writes before configuration
        cur_req = "R1";
        g_lvl = 1;
        cyc(0, 0, 0, 0, 0);
        load(16'h1234);
        run(3);
        // Mode 0 terminal count and gate pause
        cur_req = "R3";
        cfg(0); run(2); load(5); run(8);
        g_lvl = 0; run(4); g_lvl = 1; run(3);
        cur_req = "R4";
        run(3);
        g_lvl = 0; run(1); g_lvl = 1; run(3);
        // Zero count
        cur_req = "R2";
        cfg(0); load(0); run(4);
        // Mode 1 one-shot with retrigger
        cur_req = "R5";
        cfg(1); load(4); run(3);
        g_lvl = 0; run(1); g_lvl = 1; run(6);
        g_lvl = 0; run(1); g_lvl = 1; run(2);
        g_lvl = 0; run(1); g_lvl = 1; run(6);
        // Mode 2 rate generator
        cur_req = "R6";
        cfg(2); load(3); run(10, 2);
        g_lvl = 0; run(1); g_lvl = 1; run(6);
        load(1); run(4);
        // Mode 3 square wave, odd and even counts
        cur_req = "R7";
        cfg(3); load(5); run(12);
        load(4); run(9);
        load(1); run(3);
        load(2); run(5);
        load(3); run(4); g_lvl = 0; run(1); g_lvl = 1; run(7);
        // Modes 4 and 5 strobes
        cur_req = "R8";
        cfg(4); load(3); run(6);
        load(3); run(1); g_lvl = 0; run(3); g_lvl = 1; run(4);
        cfg(5); load(2); run(2);
        g_lvl = 0; run(1); g_lvl = 1; run(5);
        g_lvl = 0; run(1); g_lvl = 1; run(1); g_lvl = 0; run(1); g_lvl = 1; run(5);
        // Mode aliases and freezing by control write
        cur_req = "R9";
        cfg(6); load(3); run(7);
        cfg(7); load(5); run(6);
        cfg(0); load(9); run(3); cfg(2); run(4); load(2); run(4);
        // Same-cycle priority
        cur_req = "R10";
        cyc(1, 0, 1, 7, 1); run(2);
        load(7); run(2);
        cfg(1); load(3); g_lvl = 0; run(1);
        g_lvl = 1; cyc(0, 0, 0, 0, 1); run(3);
        g_lvl = 0; run(1); g_lvl = 1; cyc(0, 0, 1, 6, 1); run(2);
        // Terminal pulses on a repeating period
        cur_req = "R11";
        cfg(2); load(2); run(6);
        cfg(0); load(2); run(4, 2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule